// File: doc/BRIEF.md
# Cache Line Write-Back Sequencer

This block writes one dirty 8-word data-cache line back through a posted write buffer. The line is split into two 4-word halves, each with its own dirty flag. When a cache controller starts the block, it takes a copy of the line base address, the eight data words and both flags. It then sends the buffer a series of tagged pushes. An address marker opens each burst. The first word of a burst is tagged non-sequential and the words after it are tagged sequential.

The series depends on which halves are dirty. A dirty lower half always opens a burst at the line base. If the upper half is also dirty, the same burst carries on through words 4 to 7 with no second marker. If only the upper half is dirty, a new burst opens at base + 0x10. Before the first push the block waits for the buffer's post-write acceptance delay to end. After that it waits only on the buffer's full flag, and each accepted handshake moves it on by one entry. At the end it raises done together with a pulse that clears both dirty flags in the cache.

Top module: `line_evict_seq`

## Requirements
- R1: While rst_n is low and directly after it, busy_o, push_valid_o, done_o and dirty_clr_o are 0.
- R2: push_kind_o encodes 0 = address marker, 1 = non-sequential word, 2 = sequential word, and the value 3 never appears. With only the lower half dirty, the pushes are: a marker at base with data 0; word 0 (line_data_i bits 31:0) with kind 1 at base; words 1 to 3 with kind 2 at base+0x4, base+0x8 and base+0xC. Word i is line_data_i[32*i +: 32].
- R3: With both halves dirty, the R2 series is followed by words 4 to 7, all with kind 2, at base+0x10 to base+0x1C. No second marker is sent.
- R4: With only the upper half dirty, the pushes are: a marker at base+0x10 with data 0; word 4 with kind 1 at base+0x10; words 5 to 7 with kind 2 at base+0x14 to base+0x1C.
- R5: A start_i while idle with neither flag set raises done_o and dirty_clr_o in that same cycle, makes no push, and leaves busy_o at 0.
- R6: The first push appears only in the cycle after one in which gate_busy_i was sampled low. Once pushing has begun, gate_busy_i has no effect.
- R7: While buf_full_i is high the current push stays presented with its kind, address and data unchanged. Each cycle with push_valid_o high and buf_full_i low moves the series on by exactly one entry.
- R8: In the cycle after the last accepted push, done_o and dirty_clr_o are high for exactly one cycle with no push presented. busy_o is 0 after the next edge.
- R9: start_i is ignored while busy_o is high. The series in progress is neither changed nor lengthened.
- R10: The base address, data words and flags are captured at the accepted start. Changing these inputs afterwards has no effect on the pushes.
- R11: With gate_busy_i low at start, no stalls, and a series of k pushes (5 for a single half, 9 for both), done_o is high in the cycle that follows k+1 clock edges counted from the edge that samples start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request write-back of the presented line |
| base_addr_i | input | AW | Line base byte address, aligned to the line size |
| line_data_i | input | WORDS*DW | Line data, word i in bits DW*i upward |
| dirty_lo_i | input | 1 | Lower half (words 0-3) dirty |
| dirty_hi_i | input | 1 | Upper half (words 4-7) dirty |
| gate_busy_i | input | 1 | Buffer post-write acceptance delay still running |
| buf_full_i | input | 1 | Buffer cannot take a push this cycle |
| push_valid_o | output | 1 | Push presented |
| push_kind_o | output | 2 | 0 marker, 1 non-sequential word, 2 sequential word |
| push_addr_o | output | AW | Byte address of the push |
| push_data_o | output | DW | Word data; 0 for a marker |
| busy_o | output | 1 | A write-back is in progress |
| done_o | output | 1 | Write-back finished this cycle |
| dirty_clr_o | output | 1 | Clear both dirty flags of the line |

## Verification
The assertions assume a line-aligned base address, so that word addresses step by four with no carry into the tag. They also assume that buf_full_i and gate_busy_i may change freely on every cycle, and that start_i may arrive at any time. The stimulus uses only line-aligned bases. It drives the buffer-full flag from a pseudo-random sequence, raises the gate both before and during a series, and raises start_i partway through a series so that the ignore rule is exercised.

// File: rtl/lew_pkg.sv
package lew_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PUSH = 2'd2,
        ST_FIN  = 2'd3
    } lew_state_e;

    typedef enum logic [1:0] {
        PK_MARK = 2'd0,
        PK_NSEQ = 2'd1,
        PK_SEQ  = 2'd2
    } lew_kind_e;

endpackage

// File: rtl/lew_addr_gen.sv
// Maps (half, slot) to a word index and byte address.
// Slot 0 is the marker of a half, slots 1..HALF its words.
module lew_addr_gen #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic [AW-1:0]                  base_i,
    input  logic                           hi_i,
    input  logic [$clog2(WORDS/2+1)-1:0]   slot_i,
    output logic [$clog2(WORDS)-1:0]       idx_o,
    output logic [AW-1:0]                  addr_o
);
    localparam int HALF    = WORDS / 2;
    localparam int IDX_W   = $clog2(WORDS);
    localparam int HALF_SH = $clog2(HALF);
    localparam int OFF_SH  = $clog2(DW / 8);

    logic [IDX_W-1:0] first;
    logic [IDX_W-1:0] ofs;

    always_comb begin
        first  = IDX_W'(hi_i) << HALF_SH;
        ofs    = (slot_i == '0) ? '0 : IDX_W'(slot_i - 1'b1);
        idx_o  = first | ofs;
        addr_o = base_i + (AW'(idx_o) << OFF_SH);
    end
endmodule

// File: rtl/lew_word_pick.sv
module lew_word_pick #(
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic [WORDS*DW-1:0]       line_i,
    input  logic [$clog2(WORDS)-1:0]  idx_i,
    output logic [DW-1:0]             word_o
);
    logic [DW-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_split
        assign words[g] = line_i[g*DW +: DW];
    end

    assign word_o = words[idx_i];
endmodule

// File: rtl/line_evict_seq.sv
module line_evict_seq
    import lew_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [AW-1:0]         base_addr_i,
    input  logic [WORDS*DW-1:0]   line_data_i,
    input  logic                  dirty_lo_i,
    input  logic                  dirty_hi_i,
    input  logic                  gate_busy_i,
    input  logic                  buf_full_i,
    output logic                  push_valid_o,
    output logic [1:0]            push_kind_o,
    output logic [AW-1:0]         push_addr_o,
    output logic [DW-1:0]         push_data_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  dirty_clr_o
);
    localparam int HALF   = WORDS / 2;
    localparam int SLOT_W = $clog2(HALF + 1);
    localparam int IDX_W  = $clog2(WORDS);

    typedef struct packed {
        lew_state_e            st;
        logic                  hi;
        logic [SLOT_W-1:0]     slot;
        logic                  lo_dirty;
        logic                  hi_dirty;
        logic [AW-1:0]         base;
        logic [WORDS*DW-1:0]   data;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [IDX_W-1:0] word_idx;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    cur_word;
    logic             last_slot;
    logic             last_push;
    logic             accept;

    lew_addr_gen #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_addr (
        .base_i (seq_q.base),
        .hi_i   (seq_q.hi),
        .slot_i (seq_q.slot),
        .idx_o  (word_idx),
        .addr_o (cur_addr)
    );

    lew_word_pick #(.DW(DW), .WORDS(WORDS)) u_pick (
        .line_i (seq_q.data),
        .idx_i  (word_idx),
        .word_o (cur_word)
    );

    always_comb begin
        seq_d     = seq_q;
        last_slot = (seq_q.slot == SLOT_W'(HALF));
        last_push = last_slot && (seq_q.hi || !seq_q.hi_dirty);
        accept    = (seq_q.st == ST_PUSH) && !buf_full_i;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i && (dirty_lo_i || dirty_hi_i)) begin
                    seq_d.st       = ST_WAIT;
                    seq_d.hi       = !dirty_lo_i;
                    seq_d.slot     = '0;
                    seq_d.lo_dirty = dirty_lo_i;
                    seq_d.hi_dirty = dirty_hi_i;
                    seq_d.base     = base_addr_i;
                    seq_d.data     = line_data_i;
                end
            end
            ST_WAIT: begin
                if (!gate_busy_i) seq_d.st = ST_PUSH;
            end
            ST_PUSH: begin
                if (accept) begin
                    if (last_push) begin
                        seq_d.st = ST_FIN;
                    end else if (last_slot) begin
                        // lower half done, upper half continues the burst
                        seq_d.hi   = 1'b1;
                        seq_d.slot = SLOT_W'(1);
                    end else begin
                        seq_d.slot = seq_q.slot + SLOT_W'(1);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        push_valid_o = (seq_q.st == ST_PUSH);
        if (seq_q.slot == '0)
            push_kind_o = PK_MARK;
        else if (seq_q.slot == SLOT_W'(1) && (!seq_q.hi || !seq_q.lo_dirty))
            push_kind_o = PK_NSEQ;
        else
            push_kind_o = PK_SEQ;
        push_addr_o  = cur_addr;
        push_data_o  = (seq_q.slot == '0) ? '0 : cur_word;
        busy_o       = (seq_q.st != ST_IDLE);
        done_o       = (seq_q.st == ST_FIN) ||
                       (seq_q.st == ST_IDLE && start_i && !dirty_lo_i && !dirty_hi_i);
        dirty_clr_o  = done_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/lew_seq_chk.sv
module lew_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          dirty_lo_i,
    input logic          dirty_hi_i,
    input logic          gate_busy_i,
    input logic          buf_full_i,
    input logic          push_valid_o,
    input logic [1:0]    push_kind_o,
    input logic [AW-1:0] push_addr_o,
    input logic [DW-1:0] push_data_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          dirty_clr_o
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid_o |-> push_kind_o != 2'd3);                              // R2

    AST_OPEN_WITH_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_valid_o) |-> push_kind_o == 2'd0);                       // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid_o && !buf_full_i && push_kind_o != 2'd0 |=>
        !push_valid_o || (push_kind_o == 2'd2 &&
                          push_addr_o == $past(push_addr_o) + STEP));       // R3

    AST_MARKER_THEN_NSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid_o && !buf_full_i && push_kind_o == 2'd0 |=>
        push_valid_o && push_kind_o == 2'd1);                               // R4

    AST_EMPTY_LINE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i && !dirty_lo_i && !dirty_hi_i |->
        done_o && dirty_clr_o && !push_valid_o);                            // R5

    AST_GATE_BEFORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_valid_o) |-> !$past(gate_busy_i));                       // R6

    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid_o && buf_full_i |=>
        push_valid_o && $stable(push_kind_o) && $stable(push_addr_o) &&
        $stable(push_data_o));                                              // R7

    AST_DONE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> dirty_clr_o && !push_valid_o);                           // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && busy_o |=> !busy_o);                                      // R8
endmodule

bind line_evict_seq lew_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dirty_lo_i   (dirty_lo_i),
    .dirty_hi_i   (dirty_hi_i),
    .gate_busy_i  (gate_busy_i),
    .buf_full_i   (buf_full_i),
    .push_valid_o (push_valid_o),
    .push_kind_o  (push_kind_o),
    .push_addr_o  (push_addr_o),
    .push_data_o  (push_data_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .dirty_clr_o  (dirty_clr_o)
);

// File: tb/line_evict_seq_tb.sv
`timescale 1ns/1ps
module line_evict_seq_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int WORDS = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [AW-1:0]        base_addr_i = '0;
    logic [WORDS*DW-1:0]  line_data_i = '0;
    logic                 dirty_lo_i = 1'b0;
    logic                 dirty_hi_i = 1'b0;
    logic                 gate_busy_i = 1'b0;
    logic                 buf_full_i = 1'b0;
    logic                 push_valid_o;
    logic [1:0]           push_kind_o;
    logic [AW-1:0]        push_addr_o;
    logic [DW-1:0]        push_data_o;
    logic                 busy_o;
    logic                 done_o;
    logic                 dirty_clr_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    line_evict_seq #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic exp_add(input logic [1:0] kind, input logic [AW-1:0] addr,
                           input logic [DW-1:0] data, input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        sb.push_back(e);
    endtask

    // scoreboard monitor: every accepted push is compared with the queue head
    always @(negedge clk) begin
        if (rst_n && push_valid_o && !buf_full_i) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 unexpected push: actual %0h expected none",
                         {push_kind_o, push_addr_o, push_data_o});
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(push_kind_o == e.kind && push_addr_o == e.addr && push_data_o == e.data,
                    e.req, "push kind/addr/data",
                    96'({push_kind_o, push_addr_o, push_data_o}),
                    96'({e.kind, e.addr, e.data}));
            end
        end
    end

    task automatic run_job(input logic [AW-1:0] base, input logic lo, input logic hi,
                           input int gate_n, input bit stall, input bit poke,
                           input int exp_cyc, input string tag);
        logic [WORDS*DW-1:0] line;
        int n;
        for (int i = 0; i < WORDS; i++)
            line[i*DW +: DW] = {base[23:8], 8'hC3 ^ base[7:0], 8'(i)};
        if (lo) begin
            exp_add(2'd0, base, '0, "R2");
            exp_add(2'd1, base, line[0 +: DW], "R2");
            for (int i = 1; i < 4; i++) exp_add(2'd2, base + AW'(4*i), line[i*DW +: DW], "R2");
        end
        if (hi) begin
            if (!lo) begin
                exp_add(2'd0, base + 32'h10, '0, "R4");
                exp_add(2'd1, base + 32'h10, line[4*DW +: DW], "R4");
            end else begin
                exp_add(2'd2, base + 32'h10, line[4*DW +: DW], "R3");
            end
            for (int i = 5; i < 8; i++)
                exp_add(2'd2, base + AW'(4*i), line[i*DW +: DW], lo ? "R3" : "R4");
        end
        base_addr_i = base; line_data_i = line;
        dirty_lo_i = lo; dirty_hi_i = hi;
        start_i = 1'b1; gate_busy_i = (gate_n > 0); buf_full_i = 1'b0;
        @(posedge clk);
        n = 0;
        #1;
        start_i = 1'b0;
        // R10: scramble the inputs after capture
        base_addr_i = ~base; line_data_i = ~line;
        dirty_lo_i = ~lo; dirty_hi_i = ~hi;
        forever begin
            @(negedge clk);
            if (gate_n > 0 && n <= gate_n)
                chk(!push_valid_o, "R6", {tag, " push while gated"}, 96'(push_valid_o), 96'(0));
            if (done_o) break;
            @(posedge clk);
            n++;
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            buf_full_i  = stall & lfsr[0];
            gate_busy_i = (n < gate_n) || (gate_n > 0 && n >= gate_n + 3);
            start_i     = poke && (n == 3);
            if (poke && n == 3) begin
                dirty_lo_i = 1'b1; dirty_hi_i = 1'b1;
            end
        end
        chk(dirty_clr_o, "R8", {tag, " dirty clear with done"}, 96'(dirty_clr_o), 96'(1));
        chk(sb.size() == 0, "R8", {tag, " pushes left at done"}, 96'(sb.size()), 96'(0));
        if (exp_cyc >= 0)
            chk(n == exp_cyc, "R11", {tag, " cycles to done"}, 96'(n), 96'(exp_cyc));
        @(posedge clk);
        #1;
        start_i = 1'b0; gate_busy_i = 1'b0; buf_full_i = 1'b0;
        chk(!busy_o && !done_o, "R8", {tag, " idle after done"}, 96'({busy_o, done_o}), 96'(0));
        sb.delete();
    endtask

    task automatic main_flow();
        repeat (3) @(posedge clk);
        #1;
        chk(!busy_o && !push_valid_o && !done_o && !dirty_clr_o, "R1", "reset outputs",
            96'({busy_o, push_valid_o, done_o, dirty_clr_o}), 96'(0));
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(!busy_o && !push_valid_o, "R1", "after reset release",
            96'({busy_o, push_valid_o}), 96'(0));

        run_job(32'h1000_0040, 1'b1, 1'b0, 0, 1'b0, 1'b0, 6,  "lower only");
        run_job(32'h2000_0100, 1'b1, 1'b1, 0, 1'b0, 1'b0, 10, "both halves");
        run_job(32'h0300_0020, 1'b0, 1'b1, 0, 1'b0, 1'b0, 6,  "upper only");

        // R5: neither half dirty
        base_addr_i = 32'h0400_0000; dirty_lo_i = 1'b0; dirty_hi_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        chk(done_o && dirty_clr_o && !push_valid_o, "R5", "clean line done same cycle",
            96'({done_o, dirty_clr_o, push_valid_o}), 96'(3'b110));
        @(posedge clk);
        #1;
        start_i = 1'b0;
        chk(!busy_o, "R5", "clean line leaves idle", 96'(busy_o), 96'(0));
        @(negedge clk);
        chk(!push_valid_o && !done_o, "R5", "clean line no push",
            96'({push_valid_o, done_o}), 96'(0));

        run_job(32'h0500_0080, 1'b1, 1'b0, 4, 1'b0, 1'b0, 10, "gated lower");
        run_job(32'h0600_01E0, 1'b1, 1'b1, 0, 1'b1, 1'b0, -1, "stalled both");
        run_job(32'h0700_0060, 1'b0, 1'b1, 0, 1'b1, 1'b1, -1, "stalled upper poked");
        run_job(32'h0800_0200, 1'b1, 1'b1, 0, 1'b0, 1'b1, 10, "both poked");
        run_job(32'h0900_00A0, 1'b1, 1'b1, 2, 1'b1, 1'b0, -1, "gated stalled both");
        repeat (4) @(posedge clk);
    endtask

    initial begin
        fork
            main_flow();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule